// File: doc/BRIEF.md
# Streaming Syndrome and Erasure-Locator Calculator

This block sits at the front of a Reed-Solomon error-and-erasure decoder. It takes a received codeword one symbol per cycle, highest-order coefficient first, with a per-symbol erasure flag. It evaluates the received polynomial at the first 2t powers of the primitive element α by Horner's rule, and a Montgomery multiplier performs every multiply. In the same pass it records, for every flagged symbol, the field element α^j that names that symbol's polynomial position j. After the last symbol it publishes the syndromes, the erasure locators and their count, then pulses `done`.

Code length n (up to 255), correction capability t (1 to 16), field degree m (2 to 8) and the field polynomial p(x) are configuration inputs that apply at run time. Sixteen accumulators are built. When 2t exceeds sixteen, the first pass yields S1..S16 and the block asks upstream to present the same codeword again, and the second pass yields S17..S2t. If S1..S16 are all zero after the first pass, the second pass is skipped and an error-free result is reported at once.

Top module: `rs_syn_erasure_unit`

## Requirements
- R1: After a codeword, syndrome slot i-1 of `syn_out` (bits [8i-1:8i-8]) holds S_i = R(α^i) for i = 1..2t, where the first accepted symbol is coefficient R_(n-1) and α is the element x of GF(2)[x]/p(x); slots at or above 2t read zero.
- R2: `cfg_m`, `cfg_poly` (bit m and bit 0 set, bits above m clear), `cfg_n` (2..255) and `cfg_t` (1..16) are honoured at run time when they are stable from one cycle before a codeword's first symbol until its last symbol (both passes).
- R3: Each symbol accepted with `in_erase` high in the first pass stores α^(n-1-k) into the next free slot of `era_out` (slot s in bits [8s+7:8s], in arrival order), where k is the 0-based arrival index; `era_cnt` gives the number stored and unused slots read zero.
- R4: If more than 16 symbols are flagged, `era_cnt` stays at 16, `era_ovf` is set, and the stored locators are those of the first 16 flagged symbols.
- R5: `done` is a one-cycle pulse in the cycle after the final symbol of a codeword; results hold until the next publication.
- R6: With 2t > 16 and any of S1..S16 nonzero, `rerun_req` pulses (instead of `done`) in the cycle after the first pass's last symbol; the next n accepted symbols, the same codeword again, produce S17..S2t, and `done` follows the second pass.
- R7: With 2t > 16 and S1..S16 all zero, `done` follows the first pass with `no_error` = 1, no `rerun_req`, and slots 16..31 zero.
- R8: `no_error` is 1 at `done` exactly when every computed syndrome is zero; it is 0 after a second pass.
- R9: Cycles with `in_valid` low are skipped: no symbol is counted and no accumulator or locator changes.
- R10: After reset `done`, `rerun_req`, `no_error`, `era_ovf`, `era_cnt`, `syn_out` and `era_out` are zero.
- R11: `in_erase` is ignored during a second pass: the locators and count published at `done` are those of the first pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_n | input | 8 | Code length n |
| cfg_t | input | 5 | Correction capability t |
| cfg_m | input | 4 | Field degree m |
| cfg_poly | input | 9 | Field polynomial p(x), bit i = coefficient of x^i |
| in_valid | input | 1 | Symbol present this cycle |
| in_sym | input | 8 | Received symbol (low m bits used) |
| in_erase | input | 1 | Symbol is an erasure |
| done | output | 1 | Results published (one-cycle pulse) |
| rerun_req | output | 1 | Present the codeword again for the upper syndromes |
| no_error | output | 1 | All computed syndromes are zero |
| syn_out | output | 256 | 32 syndrome slots of 8 bits |
| era_out | output | 128 | 16 erasure locator slots of 8 bits |
| era_cnt | output | 5 | Number of stored erasure locators |
| era_ovf | output | 1 | More erasures flagged than slots |

## Verification
Two things collide when an erasure is flagged on the final symbol of a codeword: the locator must be written as α^0 into its slot in the same cycle that the results are published, and in the same cycle the next codeword may begin back to back and clear the accumulators. The bench provokes this with an erasure on the last symbol, followed at once by a codeword with no idle gap. A scoreboard compares the published locators, count and syndromes against values computed from field arithmetic, so a locator lost or aged once too often shows up as a mismatch. The overflow boundary and the second-pass erasure mask are judged the same way.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int MW   = 8;                 // largest field degree
  localparam int NACC = 16;                // syndrome accumulators per pass
  localparam int NSYN = 2 * NACC;          // syndrome slots over two passes
  localparam int NERA = 16;                // erasure locator slots
  localparam int NMAX = 255;               // longest code length
  localparam int CW   = $clog2(NMAX + 1);  // symbol counter width
  localparam int TW   = $clog2(NACC + 1);  // t field width
  localparam int T2W  = TW + 1;            // 2t width
  localparam int MBW  = $clog2(MW + 1);    // degree field width
  localparam int ECW  = $clog2(NERA + 1);  // erasure count width

  // multiply by x modulo p(x) for a field of run-time degree m
  function automatic logic [MW-1:0] gf_xtime(input logic [MW-1:0] a,
                                             input logic [MW:0]   poly,
                                             input logic [MBW-1:0] m);
    logic [MW:0] s;
    s = {a, 1'b0};
    if (s[m]) s = s ^ poly;
    return s[MW-1:0];
  endfunction
endpackage

// File: rtl/gf_mont_mul.sv
module gf_mont_mul
  import rs_syn_pkg::*;
(
  input  logic [MW-1:0]  a,
  input  logic [MW-1:0]  b,
  input  logic [MW:0]    poly,
  input  logic [MBW-1:0] m,
  output logic [MW-1:0]  y
);
  // LSB-first Montgomery product: y = a * b * x^-m mod p(x)
  logic [MW:0] c;
  always_comb begin
    c = '0;
    for (int j = 0; j < MW; j++) begin
      if (MBW'(j) < m) begin
        if (a[j]) c = c ^ {1'b0, b};
        if (c[0]) c = c ^ poly;
        c = c >> 1;
      end
    end
    y = c[MW-1:0];
  end
endmodule

// File: rtl/gf_const_table.sv
module gf_const_table
  import rs_syn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MW:0]              poly,
  input  logic [MBW-1:0]           m,
  output logic [NSYN-1:0][MW-1:0]  k_tab
);
  // entry i-1 = alpha^(i+m): a Montgomery product with it yields a factor alpha^i
  logic [MW:0]   pm;
  logic [MW-1:0] chain [NSYN];

  assign pm = poly ^ ((MW+1)'(1) << m);   // low part is x^m mod p(x)

  for (genvar g = 0; g < NSYN; g++) begin : g_chain
    if (g == 0) begin : g_head
      assign chain[g] = gf_xtime(pm[MW-1:0], poly, m);
    end else begin : g_link
      assign chain[g] = gf_xtime(chain[g-1], poly, m);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_tab <= '0;
    end else begin
      for (int g = 0; g < NSYN; g++) k_tab[g] <= chain[g];
    end
  end
endmodule

// File: rtl/syn_acc_bank.sv
module syn_acc_bank
  import rs_syn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     first,
  input  logic [MW-1:0]            sym,
  input  logic [MW:0]              poly,
  input  logic [MBW-1:0]           m,
  input  logic [NACC-1:0][MW-1:0]  k_sel,
  output logic [NACC-1:0][MW-1:0]  acc_nx
);
  logic [MW-1:0] acc  [NACC];
  logic [MW-1:0] prod [NACC];

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    gf_mont_mul u_mul (
      .a    (acc[i]),
      .b    (k_sel[i]),
      .poly (poly),
      .m    (m),
      .y    (prod[i])
    );

    assign acc_nx[i] = first ? sym : (prod[i] ^ sym);

    always_ff @(posedge clk) begin
      if (rst)       acc[i] <= '0;
      else if (step) acc[i] <= acc_nx[i];
    end
  end

  // R1: the opening symbol of a pass seeds every accumulator
  assert_seed_R1: assert property (@(posedge clk) disable iff (rst)
    (step && first) |=> (acc[0] == $past(sym) && acc[NACC-1] == $past(sym)));
endmodule

// File: rtl/era_capture.sv
module era_capture
  import rs_syn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     first,
  input  logic                     flag,
  input  logic [MW:0]              poly,
  input  logic [MBW-1:0]           m,
  output logic [NERA-1:0][MW-1:0]  era_nx,
  output logic [ECW-1:0]           cnt_nx,
  output logic                     ovf_nx
);
  logic [MW-1:0]  era_q [NERA];
  logic [ECW-1:0] cnt_q;
  logic           ovf_q;
  logic [ECW-1:0] base_cnt;
  logic           base_ovf;
  logic           full;
  logic [MW-1:0]  base;

  // every stored locator ages by one power of alpha per later symbol
  always_comb begin
    base_cnt = first ? '0 : cnt_q;
    base_ovf = first ? 1'b0 : ovf_q;
    full     = (base_cnt == ECW'(NERA));
    for (int j = 0; j < NERA; j++) begin
      base      = first ? '0 : era_q[j];
      era_nx[j] = gf_xtime(base, poly, m);
      if (flag && !full && base_cnt == ECW'(j)) era_nx[j] = MW'(1);
    end
    cnt_nx = (flag && !full) ? base_cnt + 1'b1 : base_cnt;
    ovf_nx = base_ovf | (flag & full);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NERA; j++) era_q[j] <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (step) begin
      for (int j = 0; j < NERA; j++) era_q[j] <= era_nx[j];
      cnt_q <= cnt_nx;
      ovf_q <= ovf_nx;
    end
  end

  // R3: a flagged symbol with room left takes exactly one new slot
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (step && flag && !first && cnt_q < ECW'(NERA)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4: the count never passes the number of slots
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ECW'(NERA));
endmodule

// File: rtl/rs_syn_erasure_unit.sv
module rs_syn_erasure_unit
  import rs_syn_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CW-1:0]           cfg_n,
  input  logic [TW-1:0]           cfg_t,
  input  logic [MBW-1:0]          cfg_m,
  input  logic [MW:0]             cfg_poly,
  input  logic                    in_valid,
  input  logic [MW-1:0]           in_sym,
  input  logic                    in_erase,
  output logic                    done,
  output logic                    rerun_req,
  output logic                    no_error,
  output logic [NSYN-1:0][MW-1:0] syn_out,
  output logic [NERA-1:0][MW-1:0] era_out,
  output logic [ECW-1:0]          era_cnt,
  output logic                    era_ovf
);
  logic [CW-1:0]             cnt_q;
  logic                      pass_q;
  logic [T2W-1:0]            twot;
  logic                      two_pass;
  logic                      first, last;
  logic                      half_zero;
  logic [NSYN-1:0][MW-1:0]   k_tab;
  logic [NACC-1:0][MW-1:0]   k_sel;
  logic [NACC-1:0][MW-1:0]   acc_nx;
  logic [NERA-1:0][MW-1:0]   era_nx;
  logic [ECW-1:0]            cnt_nx;
  logic                      ovf_nx;

  assign twot     = {cfg_t, 1'b0};
  assign two_pass = (twot > T2W'(NACC));
  assign first    = in_valid && (cnt_q == '0);
  assign last     = in_valid && (cnt_q == cfg_n - CW'(1));

  for (genvar i = 0; i < NACC; i++) begin : g_ksel
    assign k_sel[i] = pass_q ? k_tab[NACC+i] : k_tab[i];
  end

  gf_const_table u_ktab (
    .clk   (clk),
    .rst   (rst),
    .poly  (cfg_poly),
    .m     (cfg_m),
    .k_tab (k_tab)
  );

  syn_acc_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid),
    .first  (first),
    .sym    (in_sym),
    .poly   (cfg_poly),
    .m      (cfg_m),
    .k_sel  (k_sel),
    .acc_nx (acc_nx)
  );

  era_capture u_era (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid && !pass_q),
    .first  (first),
    .flag   (in_erase),
    .poly   (cfg_poly),
    .m      (cfg_m),
    .era_nx (era_nx),
    .cnt_nx (cnt_nx),
    .ovf_nx (ovf_nx)
  );

  always_comb begin
    half_zero = 1'b1;
    for (int i = 0; i < NACC; i++) begin
      if (T2W'(i) < twot && acc_nx[i] != '0) half_zero = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      pass_q    <= 1'b0;
      done      <= 1'b0;
      rerun_req <= 1'b0;
      no_error  <= 1'b0;
      syn_out   <= '0;
      era_out   <= '0;
      era_cnt   <= '0;
      era_ovf   <= 1'b0;
    end else begin
      done      <= 1'b0;
      rerun_req <= 1'b0;
      if (in_valid) cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (last) begin
        if (!pass_q) begin
          for (int i = 0; i < NACC; i++) begin
            syn_out[i]      <= (T2W'(i) < twot) ? acc_nx[i] : '0;
            syn_out[NACC+i] <= '0;
          end
          era_out <= era_nx;
          era_cnt <= cnt_nx;
          era_ovf <= ovf_nx;
          if (two_pass && !half_zero) begin
            rerun_req <= 1'b1;
            pass_q    <= 1'b1;
          end else begin
            done     <= 1'b1;
            no_error <= half_zero;
          end
        end else begin
          for (int i = 0; i < NACC; i++) begin
            syn_out[NACC+i] <= (T2W'(NACC+i) < twot) ? acc_nx[i] : '0;
          end
          done     <= 1'b1;
          no_error <= 1'b0;
          pass_q   <= 1'b0;
        end
      end
    end
  end

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: a rerun request is never a completion, nor followed by one at once
  assert_rerun_excl_R6: assert property (@(posedge clk) disable iff (rst)
    rerun_req |-> !done);
  assert_rerun_gap_R6: assert property (@(posedge clk) disable iff (rst)
    rerun_req |=> !done);
  // R4: overflow only with every slot taken
  assert_ovf_full_R4: assert property (@(posedge clk) disable iff (rst)
    era_ovf |-> (era_cnt == ECW'(NERA)));
  // R8: an error-free verdict never comes with a nonzero first syndrome
  assert_noerr_R8: assert property (@(posedge clk) disable iff (rst)
    (done && no_error) |-> (syn_out[0] == '0));
endmodule

// File: tb/rs_syn_erasure_unit_tb.sv
module rs_syn_erasure_unit_tb;
  import rs_syn_pkg::*;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [CW-1:0]           cfg_n = '0;
  logic [TW-1:0]           cfg_t = '0;
  logic [MBW-1:0]          cfg_m = '0;
  logic [MW:0]             cfg_poly = '0;
  logic                    in_valid = 1'b0;
  logic [MW-1:0]           in_sym = '0;
  logic                    in_erase = 1'b0;
  logic                    done, rerun_req, no_error, era_ovf;
  logic [NSYN-1:0][MW-1:0] syn_out;
  logic [NERA-1:0][MW-1:0] era_out;
  logic [ECW-1:0]          era_cnt;

  always #2.5 clk = ~clk;

  rs_syn_erasure_unit u_dut (
    .clk(clk), .rst(rst), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_m(cfg_m),
    .cfg_poly(cfg_poly), .in_valid(in_valid), .in_sym(in_sym), .in_erase(in_erase),
    .done(done), .rerun_req(rerun_req), .no_error(no_error), .syn_out(syn_out),
    .era_out(era_out), .era_cnt(era_cnt), .era_ovf(era_ovf)
  );

  typedef struct packed {
    logic [NSYN-1:0][MW-1:0] syn;
    logic [NERA-1:0][MW-1:0] era;
    logic [ECW-1:0]          cnt;
    logic                    ovf;
    logic                    noerr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    tests = 0;
  int    fails = 0;
  bit    finished = 0;
  int    sym_buf [256];
  bit    era_buf [256];
  int    cur_m = 0, cur_poly = 0, cur_n = 0, cur_t = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int bxt(input int a);
    int r;
    r = a << 1;
    if (r & (1 << cur_m)) r = r ^ cur_poly;
    return r;
  endfunction

  function automatic int bmul(input int a, input int b);
    int r = 0;
    for (int bit_i = cur_m - 1; bit_i >= 0; bit_i--) begin
      r = bxt(r);
      if ((b >> bit_i) & 1) r = r ^ a;
    end
    return r;
  endfunction

  function automatic int bpow(input int e);
    int r = 1;
    for (int k = 0; k < e; k++) r = bxt(r);
    return r;
  endfunction

  task automatic drive_pass(input int n, input bit gaps, input bit force_erase);
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0;
        in_erase = 1'b1;           // idle cycle with erase high: must be skipped (R9)
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sym   = MW'(sym_buf[k]);
      in_erase = force_erase ? 1'b1 : era_buf[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_erase = 1'b0;
  endtask

  task automatic run_cw(input int n, input int t, input int m, input int poly,
                        input bit gaps, input bit p2_erase, input string tag);
    exp_t e;
    int   s, ai, c;
    bit   lowzero, allzero, rerun_exp;
    if (m != cur_m || poly != cur_poly || n != cur_n || t != cur_t) begin
      cfg_m = MBW'(m); cfg_poly = (MW+1)'(poly); cfg_n = CW'(n); cfg_t = TW'(t);
      cur_m = m; cur_poly = poly; cur_n = n; cur_t = t;
      @(negedge clk);              // R2: settle one cycle before the first symbol
    end
    e = '0;
    lowzero = 1; allzero = 1;
    for (int i = 1; i <= 2 * t; i++) begin
      ai = bpow(i);
      s  = 0;
      for (int k = 0; k < n; k++) s = bmul(s, ai) ^ sym_buf[k];
      e.syn[i-1] = MW'(s);
      if (s != 0) begin
        allzero = 0;
        if (i <= NACC) lowzero = 0;
      end
    end
    c = 0;
    for (int k = 0; k < n; k++) begin
      if (era_buf[k]) begin
        if (c < NERA) begin
          e.era[c] = MW'(bpow(n - 1 - k));
          c++;
        end else begin
          e.ovf = 1'b1;
        end
      end
    end
    e.cnt = ECW'(c);
    rerun_exp = (2 * t > NACC) && !lowzero;
    if (2 * t > NACC) begin
      e.noerr = lowzero;
      if (lowzero) for (int i = NACC; i < NSYN; i++) e.syn[i] = '0;
    end else begin
      e.noerr = allzero;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    drive_pass(n, gaps, 1'b0);
    check(rerun_req == rerun_exp, rerun_exp ? "R6" : "R7", {tag, " rerun_req"},
          256'(rerun_req), 256'(rerun_exp));
    if (rerun_exp) drive_pass(n, gaps, p2_erase);
  endtask

  // monitor: pop an expectation on each completion
  always @(negedge clk) begin
    exp_t  e;
    string tg;
    if (!rst && done && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected done", 256'(1), 256'(0));
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(syn_out == e.syn, "R1", {tg, " syndromes"}, 256'(syn_out), 256'(e.syn));
        check(era_out == e.era, "R3", {tg, " erasure locators"}, 256'(era_out), 256'(e.era));
        check(era_cnt == e.cnt, "R3", {tg, " erasure count"}, 256'(era_cnt), 256'(e.cnt));
        check(era_ovf == e.ovf, "R4", {tg, " overflow"}, 256'(era_ovf), 256'(e.ovf));
        check(no_error == e.noerr, "R8", {tg, " no_error"}, 256'(no_error), 256'(e.noerr));
      end
    end
  end

  task automatic fill(input int n, input int m, input bit zero);
    for (int k = 0; k < 256; k++) begin
      sym_buf[k] = zero ? 0 : ($urandom & ((1 << m) - 1));
      era_buf[k] = 1'b0;
    end
    if (!zero) sym_buf[0] = sym_buf[0] | 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(done == 1'b0 && rerun_req == 1'b0, "R10", "done/rerun after reset", 256'({done, rerun_req}), 256'(0));
    check(no_error == 1'b0, "R10", "no_error after reset", 256'(no_error), 256'(0));
    check(syn_out == '0, "R10", "syndromes after reset", 256'(syn_out), 256'(0));
    check(era_out == '0 && era_cnt == '0, "R10", "erasures after reset", 256'(era_out), 256'(0));
    check(era_ovf == 1'b0, "R10", "overflow after reset", 256'(era_ovf), 256'(0));

    // R1 R2 R3: GF(2^8), erasures at start, middle and final symbol
    fill(20, 8, 0);
    era_buf[0] = 1; era_buf[7] = 1; era_buf[19] = 1;
    run_cw(20, 4, 8, 'h11D, 0, 0, "R1 R2 R3 m8 t4");
    // back to back, no idle: R5 boundary
    fill(20, 8, 0);
    era_buf[19] = 1;
    run_cw(20, 4, 8, 'h11D, 0, 0, "R5 back-to-back last-symbol erasure");

    // R8: all-zero word in GF(16)
    fill(15, 4, 1);
    run_cw(15, 3, 4, 'h13, 0, 0, "R8 zero word m4");
    fill(15, 4, 0);
    era_buf[14] = 1; era_buf[2] = 1;
    run_cw(15, 3, 4, 'h13, 0, 0, "R2 m4 random");

    // R6 R11: two passes, erase held high through the second pass
    fill(30, 8, 0);
    era_buf[3] = 1;
    run_cw(30, 10, 8, 'h11D, 0, 1, "R6 R11 two-pass");

    // R7: early termination
    fill(10, 8, 1);
    run_cw(10, 12, 8, 'h11D, 0, 0, "R7 early stop");

    // R4: eighteen erasures in GF(32)
    fill(25, 5, 0);
    for (int k = 0; k < 18; k++) era_buf[k] = 1;
    run_cw(25, 2, 5, 'h25, 0, 0, "R4 overflow");

    // R9: gaps in the stream
    fill(40, 8, 0);
    era_buf[5] = 1; era_buf[39] = 1;
    run_cw(40, 8, 8, 'h11D, 0, 0, "R9 no gaps");
    fill(40, 8, 0);
    era_buf[5] = 1; era_buf[39] = 1;
    run_cw(40, 8, 8, 'h11D, 1, 0, "R9 with gaps");

    // R6: full t=16 in GF(64) with gaps
    fill(63, 6, 0);
    run_cw(63, 16, 6, 'h43, 1, 0, "R6 t16 m6");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5", "completions outstanding", 256'(exp_q.size()), 256'(0));
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule